// File: doc/BRIEF.md
# Multiply-Accumulate Unit with Extended Accumulator

This block multiplies two signed 16-bit operands and merges the 32-bit product into a 40-bit accumulator. The product can replace the accumulator, be added to it or be subtracted from it. Eight guard bits above the signed 32-bit range let a run of accumulations overshoot that range without wrapping. A status flag shows when the accumulator holds significant bits above bit 31. A saturate operation clamps such a value back to the largest or smallest signed 32-bit value, and a clear operation zeros it.

The X operand comes from one of two local X registers or from an external result bus. The Y operand comes from one of two local Y registers or from a 16-bit feedback register. An arithmetic result can go to the accumulator or to the feedback register. The feedback register keeps result bits 31..16, so a scaled product can be the next Y operand with no trip through the register files.

The accumulator has three parts: high (8 bits), middle (16 bits) and low (16 bits). Each part has its own direct load and its own output. All state is sampled at the start of a cycle and updated at the clock edge that ends it. A register can therefore feed an operand and take a new value in the same cycle.

Top module: `mac_unit`

## Requirements
- R1: A synchronous active-high reset clears the operand registers, the accumulator, the feedback register and the overflow flag to zero.
- R2: `xreg_wr_en` loads `xreg_wr_data` into X register `xreg_wr_idx`, and `yreg_wr_en` does the same for the Y registers. `x_sel` picks the X operand: 0 selects X register 0, 1 selects X register 1, 2 or 3 selects `rbus_in`. `y_sel` picks the Y operand: 0 selects Y register 0, 1 selects Y register 1, 2 or 3 selects the feedback register.
- R3: Operation codes are 0 no-op, 1 multiply, 2 multiply-add, 3 multiply-subtract, 4 clear and 5 saturate (6 and 7 act as no-op). For multiply, the signed product of X and Y, sign-extended to 40 bits, replaces the accumulator.
- R4: Multiply-add stores accumulator plus product, and multiply-subtract stores accumulator minus product. Both use 40-bit two's-complement arithmetic.
- R5: After every clock edge, `ovf` is 1 exactly when accumulator bits 39..31 are not all equal.
- R6: When `dest` is 1, an arithmetic operation (codes 1 to 3) writes result bits 31..16 to the feedback register and leaves the accumulator and `ovf` unchanged. When `dest` is 0, the result goes to the accumulator.
- R7: A feedback value written at one edge can be used as the Y operand in the next cycle.
- R8: Clear sets all 40 accumulator bits to zero and drops `ovf`.
- R9: If the overflow condition holds, saturate replaces the accumulator with 0x007FFFFFFF when bit 39 is 0 and with 0xFF80000000 when bit 39 is 1. Otherwise saturate leaves the accumulator unchanged.
- R10: `ld_lo_en` writes `ld_data` to bits 15..0. `ld_mid_en` writes `ld_data` to bits 31..16 and fills bits 39..32 with `ld_data[15]`. `ld_hi_en` writes `ld_data[7:0]` to bits 39..32 and overrides that fill. In any cycle with a direct load, the operation does not write the accumulator.
- R11: An operand register written in the same cycle it is selected supplies its old value. The new value is used from the next cycle.
- R12: A no-op cycle with no loads leaves the accumulator, the feedback register and `ovf` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xreg_wr_en | input | 1 | Write enable for the X registers |
| xreg_wr_idx | input | 1 | X register index |
| xreg_wr_data | input | 16 | X register write data |
| yreg_wr_en | input | 1 | Write enable for the Y registers |
| yreg_wr_idx | input | 1 | Y register index |
| yreg_wr_data | input | 16 | Y register write data |
| x_sel | input | 2 | X operand source |
| y_sel | input | 2 | Y operand source |
| rbus_in | input | 16 | External result-bus operand |
| op | input | 3 | Operation code |
| dest | input | 1 | 0 writes the accumulator, 1 writes the feedback register |
| ld_hi_en | input | 1 | Direct load of the high part |
| ld_mid_en | input | 1 | Direct load of the middle part |
| ld_lo_en | input | 1 | Direct load of the low part |
| ld_data | input | 16 | Direct-load data |
| acc_hi | output | 8 | Accumulator bits 39..32 |
| acc_mid | output | 16 | Accumulator bits 31..16 |
| acc_lo | output | 16 | Accumulator bits 15..0 |
| fb_out | output | 16 | Feedback register |
| ovf | output | 1 | Accumulator exceeds the signed 32-bit range |

## Verification
The multiply paths use positive, mixed-sign and most-negative operands taken from every operand source. This shows whether the product is signed and whether the right source was muxed in. Repeated multiply-adds of the largest positive square push the accumulator past bit 31 into the guard bits. This separates a 40-bit accumulator from one that wraps at 32 bits, and shows that the flag follows the guard bits. The saturate and clear tests start from overflowed values of both signs and from in-range values, so a clamp that fires wrongly shows up. Same-cycle register writes and combined direct loads show the sampling order, the sign fill of the high part and the priority of loads over operations.

// File: rtl/mac_pkg.sv
package mac_pkg;

  typedef enum logic [2:0] {
    OP_NOP = 3'd0,
    OP_MUL = 3'd1,
    OP_MAC = 3'd2,
    OP_MSU = 3'd3,
    OP_CLR = 3'd4,
    OP_SAT = 3'd5
  } mac_op_e;

  localparam logic [1:0] SRC_REG0 = 2'd0;
  localparam logic [1:0] SRC_REG1 = 2'd1;

  function automatic logic op_is_arith(input mac_op_e o);
    return (o == OP_MUL) || (o == OP_MAC) || (o == OP_MSU);
  endfunction

endpackage

// File: rtl/mac_operand_sel.sv
module mac_operand_sel #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          xwr_en,
  input  logic          xwr_idx,
  input  logic [DW-1:0] xwr_data,
  input  logic          ywr_en,
  input  logic          ywr_idx,
  input  logic [DW-1:0] ywr_data,
  input  logic [1:0]    x_sel,
  input  logic [1:0]    y_sel,
  input  logic [DW-1:0] rbus,
  input  logic [DW-1:0] fb,
  output logic [DW-1:0] x_op,
  output logic [DW-1:0] y_op
);
  import mac_pkg::*;

  localparam int NREG = 2;

  logic [DW-1:0] xr [NREG];
  logic [DW-1:0] yr [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_regs
    always_ff @(posedge clk) begin
      if (rst) begin
        xr[g] <= '0;
        yr[g] <= '0;
      end else begin
        if (xwr_en && (xwr_idx == 1'(g))) xr[g] <= xwr_data;
        if (ywr_en && (ywr_idx == 1'(g))) yr[g] <= ywr_data;
      end
    end

    // R2: a write lands in the addressed register at the next edge
    a_r2_xreg_write: assert property (@(posedge clk) disable iff (rst)
      (xwr_en && (xwr_idx == 1'(g))) |=> (xr[g] == $past(xwr_data)));
    a_r2_yreg_write: assert property (@(posedge clk) disable iff (rst)
      (ywr_en && (ywr_idx == 1'(g))) |=> (yr[g] == $past(ywr_data)));
  end

  always_comb begin
    unique case (x_sel)
      SRC_REG0: x_op = xr[0];
      SRC_REG1: x_op = xr[1];
      default:  x_op = rbus;
    endcase
    unique case (y_sel)
      SRC_REG0: y_op = yr[0];
      SRC_REG1: y_op = yr[1];
      default:  y_op = fb;
    endcase
  end

endmodule

// File: rtl/mac_arith.sv
module mac_arith #(
  parameter int DW = 16,
  parameter int GW = 8,
  localparam int PW = 2 * DW,
  localparam int AW = PW + GW
) (
  input  logic            clk,
  input  logic            rst,
  input  mac_pkg::mac_op_e op,
  input  logic [DW-1:0]   x_op,
  input  logic [DW-1:0]   y_op,
  input  logic [AW-1:0]   acc,
  output logic [AW-1:0]   res
);
  import mac_pkg::*;

  logic signed [PW-1:0] prod;
  logic        [AW-1:0] prod_ext;

  always_comb begin
    prod     = $signed({{DW{x_op[DW-1]}}, x_op}) * $signed({{DW{y_op[DW-1]}}, y_op});
    prod_ext = {{GW{prod[PW-1]}}, prod};
    unique case (op)
      OP_MUL:  res = prod_ext;
      OP_MAC:  res = acc + prod_ext;
      OP_MSU:  res = acc - prod_ext;
      default: res = acc;
    endcase
  end

  // R3: a plain product always fits the signed 32-bit range
  a_r3_product_in_range: assert property (@(posedge clk) disable iff (rst)
    (op == OP_MUL) |-> ((res[AW-1:PW-1] == '0) || (res[AW-1:PW-1] == '1)));

endmodule

// File: rtl/mac_accum.sv
module mac_accum #(
  parameter int DW = 16,
  parameter int GW = 8,
  localparam int PW = 2 * DW,
  localparam int AW = PW + GW
) (
  input  logic            clk,
  input  logic            rst,
  input  mac_pkg::mac_op_e op,
  input  logic            dest,
  input  logic [AW-1:0]   res,
  input  logic            ld_hi_en,
  input  logic            ld_mid_en,
  input  logic            ld_lo_en,
  input  logic [DW-1:0]   ld_data,
  output logic [AW-1:0]   acc,
  output logic [DW-1:0]   fb,
  output logic            ovf
);
  import mac_pkg::*;

  localparam logic [AW-1:0] SAT_POS = {{(GW + 1){1'b0}}, {(PW - 1){1'b1}}};
  localparam logic [AW-1:0] SAT_NEG = ~SAT_POS;

  function automatic logic beyond_range(input logic [AW-1:0] v);
    return !((v[AW-1:PW-1] == '0) || (v[AW-1:PW-1] == '1));
  endfunction

  logic [AW-1:0] acc_n;
  logic [DW-1:0] fb_n;
  logic          any_ld;
  logic          arith;

  always_comb begin
    acc_n  = acc;
    fb_n   = fb;
    arith  = op_is_arith(op);
    any_ld = ld_hi_en || ld_mid_en || ld_lo_en;
    if (arith && dest) fb_n = res[PW-1:DW];
    if (any_ld) begin
      if (ld_lo_en) acc_n[DW-1:0] = ld_data;
      if (ld_mid_en) begin
        acc_n[PW-1:DW] = ld_data;
        acc_n[AW-1:PW] = {GW{ld_data[DW-1]}};
      end
      if (ld_hi_en) acc_n[AW-1:PW] = ld_data[GW-1:0];
    end else begin
      unique case (op)
        OP_MUL, OP_MAC, OP_MSU: if (!dest) acc_n = res;
        OP_CLR:                 acc_n = '0;
        OP_SAT: if (beyond_range(acc)) acc_n = acc[AW-1] ? SAT_NEG : SAT_POS;
        default:                acc_n = acc;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
      fb  <= '0;
      ovf <= 1'b0;
    end else begin
      acc <= acc_n;
      fb  <= fb_n;
      ovf <= beyond_range(acc_n);
    end
  end

  // R5: the flag follows the guard bits of the stored accumulator
  a_r5_flag_tracks_guard: assert property (@(posedge clk) disable iff (rst)
    ovf == !((acc[AW-1:PW-1] == '0) || (acc[AW-1:PW-1] == '1)));
  // R8: clear without loads empties the accumulator
  a_r8_clear_zeros: assert property (@(posedge clk) disable iff (rst)
    ((op == OP_CLR) && !any_ld) |=> ((acc == '0) && !ovf));
  // R6: a feedback-bound result leaves the accumulator alone
  a_r6_fb_keeps_acc: assert property (@(posedge clk) disable iff (rst)
    (arith && dest && !any_ld) |=> ($stable(acc) && $stable(ovf)));
  // R9: saturation always ends inside the 32-bit range
  a_r9_sat_in_range: assert property (@(posedge clk) disable iff (rst)
    ((op == OP_SAT) && !any_ld) |=> !ovf);
  // R10: a middle-only load sign-fills the high part
  a_r10_mid_sign_fill: assert property (@(posedge clk) disable iff (rst)
    (ld_mid_en && !ld_hi_en) |=> (acc[AW-1:PW] == {GW{acc[PW-1]}}));
  // R12: an idle cycle holds all state
  a_r12_idle_holds: assert property (@(posedge clk) disable iff (rst)
    ((op == OP_NOP) && !any_ld) |=> ($stable(acc) && $stable(fb) && $stable(ovf)));

endmodule

// File: rtl/mac_unit.sv
module mac_unit #(
  parameter int DW = 16,
  parameter int GW = 8,
  localparam int PW = 2 * DW,
  localparam int AW = PW + GW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          xreg_wr_en,
  input  logic          xreg_wr_idx,
  input  logic [DW-1:0] xreg_wr_data,
  input  logic          yreg_wr_en,
  input  logic          yreg_wr_idx,
  input  logic [DW-1:0] yreg_wr_data,
  input  logic [1:0]    x_sel,
  input  logic [1:0]    y_sel,
  input  logic [DW-1:0] rbus_in,
  input  logic [2:0]    op,
  input  logic          dest,
  input  logic          ld_hi_en,
  input  logic          ld_mid_en,
  input  logic          ld_lo_en,
  input  logic [DW-1:0] ld_data,
  output logic [GW-1:0] acc_hi,
  output logic [DW-1:0] acc_mid,
  output logic [DW-1:0] acc_lo,
  output logic [DW-1:0] fb_out,
  output logic          ovf
);
  import mac_pkg::*;

  mac_op_e       op_e;
  logic [DW-1:0] x_op;
  logic [DW-1:0] y_op;
  logic [AW-1:0] acc;
  logic [AW-1:0] res;
  logic [DW-1:0] fb;

  assign op_e = mac_op_e'(op);

  mac_operand_sel #(.DW(DW)) u_opsel (
    .clk      (clk),
    .rst      (rst),
    .xwr_en   (xreg_wr_en),
    .xwr_idx  (xreg_wr_idx),
    .xwr_data (xreg_wr_data),
    .ywr_en   (yreg_wr_en),
    .ywr_idx  (yreg_wr_idx),
    .ywr_data (yreg_wr_data),
    .x_sel    (x_sel),
    .y_sel    (y_sel),
    .rbus     (rbus_in),
    .fb       (fb),
    .x_op     (x_op),
    .y_op     (y_op)
  );

  mac_arith #(.DW(DW), .GW(GW)) u_arith (
    .clk  (clk),
    .rst  (rst),
    .op   (op_e),
    .x_op (x_op),
    .y_op (y_op),
    .acc  (acc),
    .res  (res)
  );

  mac_accum #(.DW(DW), .GW(GW)) u_accum (
    .clk       (clk),
    .rst       (rst),
    .op        (op_e),
    .dest      (dest),
    .res       (res),
    .ld_hi_en  (ld_hi_en),
    .ld_mid_en (ld_mid_en),
    .ld_lo_en  (ld_lo_en),
    .ld_data   (ld_data),
    .acc       (acc),
    .fb        (fb),
    .ovf       (ovf)
  );

  assign acc_hi  = acc[AW-1:PW];
  assign acc_mid = acc[PW-1:DW];
  assign acc_lo  = acc[DW-1:0];
  assign fb_out  = fb;

endmodule

// File: tb/mac_unit_tb_top.sv
module mac_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic        xreg_wr_en, xreg_wr_idx, yreg_wr_en, yreg_wr_idx;
  logic [15:0] xreg_wr_data, yreg_wr_data, rbus_in, ld_data;
  logic [1:0]  x_sel, y_sel;
  logic [2:0]  op;
  logic        dest, ld_hi_en, ld_mid_en, ld_lo_en;
  logic [7:0]  acc_hi;
  logic [15:0] acc_mid, acc_lo, fb_out;
  logic        ovf;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  typedef struct {
    logic [39:0] acc;
    logic [15:0] fb;
    logic        ovf;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  logic [15:0] m_mx [2];
  logic [15:0] m_my [2];
  logic [39:0] m_acc;
  logic [15:0] m_fb;

  always #5 clk = ~clk;

  mac_unit dut_i (
    .clk(clk), .rst(rst),
    .xreg_wr_en(xreg_wr_en), .xreg_wr_idx(xreg_wr_idx), .xreg_wr_data(xreg_wr_data),
    .yreg_wr_en(yreg_wr_en), .yreg_wr_idx(yreg_wr_idx), .yreg_wr_data(yreg_wr_data),
    .x_sel(x_sel), .y_sel(y_sel), .rbus_in(rbus_in), .op(op), .dest(dest),
    .ld_hi_en(ld_hi_en), .ld_mid_en(ld_mid_en), .ld_lo_en(ld_lo_en), .ld_data(ld_data),
    .acc_hi(acc_hi), .acc_mid(acc_mid), .acc_lo(acc_lo), .fb_out(fb_out), .ovf(ovf)
  );

  function automatic logic big(input logic [39:0] v);
    return !((v[39:31] == 9'h000) || (v[39:31] == 9'h1FF));
  endfunction

  task automatic idle();
    xreg_wr_en = 0; xreg_wr_idx = 0; xreg_wr_data = '0;
    yreg_wr_en = 0; yreg_wr_idx = 0; yreg_wr_data = '0;
    x_sel = 2'd0; y_sel = 2'd0; rbus_in = '0; op = 3'd0; dest = 0;
    ld_hi_en = 0; ld_mid_en = 0; ld_lo_en = 0; ld_data = '0;
  endtask

  // Driver: model the cycle from the requirements, queue the result, advance.
  task automatic cyc(input string tag);
    logic [15:0] xv, yv;
    logic signed [31:0] pr;
    logic [39:0] pe, r, na;
    logic [15:0] nf;
    exp_t it;
    xv = (x_sel == 2'd0) ? m_mx[0] : (x_sel == 2'd1) ? m_mx[1] : rbus_in;
    yv = (y_sel == 2'd0) ? m_my[0] : (y_sel == 2'd1) ? m_my[1] : m_fb;
    pr = $signed(xv) * $signed(yv);
    pe = {{8{pr[31]}}, pr};
    na = m_acc; nf = m_fb;
    r  = (op == 3'd1) ? pe : (op == 3'd2) ? m_acc + pe : m_acc - pe;
    if ((op >= 3'd1) && (op <= 3'd3) && dest) nf = r[31:16];
    if (ld_hi_en || ld_mid_en || ld_lo_en) begin
      if (ld_lo_en) na[15:0] = ld_data;
      if (ld_mid_en) na[39:16] = {{8{ld_data[15]}}, ld_data};
      if (ld_hi_en) na[39:32] = ld_data[7:0];
    end else if ((op >= 3'd1) && (op <= 3'd3)) begin
      if (!dest) na = r;
    end else if (op == 3'd4) begin
      na = '0;
    end else if (op == 3'd5) begin
      if (big(m_acc)) na = m_acc[39] ? 40'hFF80000000 : 40'h007FFFFFFF;
    end
    if (xreg_wr_en) m_mx[xreg_wr_idx] = xreg_wr_data;
    if (yreg_wr_en) m_my[yreg_wr_idx] = yreg_wr_data;
    m_acc = na; m_fb = nf;
    it.acc = na; it.fb = nf; it.ovf = big(na); it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
    idle();
  endtask

  // Monitor: compare 2 ns after each rising edge.
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #2;
      if (sb_q.size() > 0) begin
        e = sb_q.pop_front();
        tests++;
        if ({acc_hi, acc_mid, acc_lo} !== e.acc || fb_out !== e.fb || ovf !== e.ovf) begin
          fails++;
          $display("FAIL %s: acc=%h fb=%h ovf=%b expected acc=%h fb=%h ovf=%b",
                   e.tag, {acc_hi, acc_mid, acc_lo}, fb_out, ovf, e.acc, e.fb, e.ovf);
        end
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    idle();
    rst = 1;
    m_mx[0] = '0; m_mx[1] = '0; m_my[0] = '0; m_my[1] = '0; m_acc = '0; m_fb = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    cyc("R1 reset state");

    // R2 register loads
    xreg_wr_en = 1; xreg_wr_idx = 0; xreg_wr_data = 16'd3;
    yreg_wr_en = 1; yreg_wr_idx = 0; yreg_wr_data = 16'd5;
    cyc("R2 write reg0");
    xreg_wr_en = 1; xreg_wr_idx = 1; xreg_wr_data = 16'hFFFE;
    yreg_wr_en = 1; yreg_wr_idx = 1; yreg_wr_data = 16'h7FFF;
    cyc("R2 write reg1");

    op = 3'd1; x_sel = 2'd0; y_sel = 2'd0; cyc("R3 multiply 3*5");
    op = 3'd2; x_sel = 2'd1; y_sel = 2'd0; cyc("R4 multiply-add -2*5");
    op = 3'd3; x_sel = 2'd0; y_sel = 2'd1; cyc("R4 multiply-subtract 3*7FFF");
    op = 3'd1; x_sel = 2'd2; rbus_in = 16'h8000; y_sel = 2'd0; cyc("R2 R3 bus operand");
    op = 3'd1; x_sel = 2'd3; rbus_in = 16'h8000; y_sel = 2'd1; cyc("R2 R3 sel 3 bus");

    op = 3'd1; dest = 1; x_sel = 2'd0; y_sel = 2'd1; cyc("R6 result to feedback");
    op = 3'd1; y_sel = 2'd2; x_sel = 2'd0; cyc("R7 feedback as Y");
    op = 3'd2; dest = 1; rbus_in = 16'h8000; x_sel = 2'd2; y_sel = 2'd3; cyc("R6 R7 mac to feedback");
    cyc("R12 idle holds");

    // Positive overflow and saturation
    ld_mid_en = 1; ld_lo_en = 1; ld_data = 16'h7FFF; cyc("R10 load mid+lo");
    ld_lo_en = 1; ld_data = 16'hFFFF; cyc("R10 load lo");
    op = 3'd2; x_sel = 2'd0; y_sel = 2'd0; cyc("R5 overflow positive");
    op = 3'd5; cyc("R9 saturate positive");
    op = 3'd5; cyc("R9 saturate in range no change");

    // Negative overflow and saturation
    ld_mid_en = 1; ld_data = 16'h8000; cyc("R10 mid sign fill");
    ld_lo_en = 1; ld_data = 16'h0000; cyc("R10 load lo zero");
    op = 3'd3; x_sel = 2'd0; y_sel = 2'd0; cyc("R5 overflow negative");
    op = 3'd5; cyc("R9 saturate negative");

    ld_hi_en = 1; ld_mid_en = 1; ld_data = 16'h8012; cyc("R10 R5 high overrides fill");
    op = 3'd2; ld_lo_en = 1; ld_data = 16'h1234; cyc("R10 load wins over op");
    op = 3'd4; dest = 1; cyc("R8 clear");

    // Guard bits across repeated accumulation
    for (int i = 0; i < 3; i++) begin
      op = 3'd2; x_sel = 2'd2; rbus_in = 16'h7FFF; y_sel = 2'd1; cyc("R4 R5 guard accumulate");
    end
    op = 3'd5; cyc("R9 saturate after guard growth");

    // Same-cycle read and write of an operand register
    op = 3'd1; x_sel = 2'd0; y_sel = 2'd0;
    xreg_wr_en = 1; xreg_wr_idx = 0; xreg_wr_data = 16'd100; cyc("R11 old value used");
    op = 3'd1; x_sel = 2'd0; y_sel = 2'd0; cyc("R11 new value next cycle");
    op = 3'd6; cyc("R12 unused code holds");
    op = 3'd4; cyc("R8 clear again");

    repeat (3) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule